// File: doc/BRIEF.md
# PS/2 Mouse Packet Decoder

This block listens to the two open-collector lines of a PS/2 pointing device that is already reporting in streaming mode. It recovers each 11-bit serial frame and groups the bytes into three-byte movement reports. It then publishes one event per report: a signed 9-bit horizontal step, a signed 9-bit vertical step, the three button levels and the two axis overflow flags. The event stays in output registers until the next complete report arrives, so a processor can read it at any time. A one-cycle strobe marks each new event.

The device clock runs far slower than the system clock. Both lines are brought into the system clock domain with two-flop synchronisers, and a falling edge of the device clock is found by comparing successive synchronised samples. Reports are realigned at their first byte: the byte that opens a report always has a marker bit set. A broken frame discards the report that is being collected. A frame that stops halfway is discarded once the line has been quiet for a set number of cycles.

Top module: `ps2_mouse_decoder`

## Requirements
- R1: After reset, `evt_valid` is 0 and `dx`, `dy`, all button outputs and both overflow outputs are 0.
- R2: A byte is taken from 11 data-line samples, each captured at a falling device-clock edge. The samples are a start bit of 0, eight data bits least significant first, a parity bit that makes the nine data and parity bits hold an odd number of ones, and a stop bit of 1.
- R3: The first byte of a report sets `btn_left` from bit 0, `btn_right` from bit 1, `btn_middle` from bit 2, `ovf_x` from bit 6 and `ovf_y` from bit 7.
- R4: `dx` is the first byte's bit 4 placed above the second byte, and `dy` is the first byte's bit 5 placed above the third byte. Each is a 9-bit two's-complement value, positive meaning right or up.
- R5: `evt_valid` is high for exactly one system clock cycle per completed report. That cycle starts at the third rising system clock edge after the falling device-clock edge that delivers the third byte's stop bit.
- R6: Between reports, all event outputs keep their values. A report that is only partly received changes none of them.
- R7: A byte arriving when a report is expected to start is dropped unless its bit 3 is 1.
- R8: A frame with a wrong start, parity or stop bit abandons the report in progress. The next good byte is treated as the opening byte of a new report.
- R9: If a frame has started and no falling device-clock edge follows for `IDLE_CYCLES` system cycles, the partial frame is discarded. The next falling edge is then taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk | input | 1 | Device clock line (asynchronous) |
| ps2_dat | input | 1 | Device data line (asynchronous) |
| evt_valid | output | 1 | One-cycle strobe for a new event |
| dx | output | 9 | Signed horizontal displacement |
| dy | output | 9 | Signed vertical displacement |
| btn_left | output | 1 | Left button level |
| btn_right | output | 1 | Right button level |
| btn_middle | output | 1 | Middle button level |
| ovf_x | output | 1 | Horizontal overflow flag |
| ovf_y | output | 1 | Vertical overflow flag |

## Verification
The strobe and event registers update three system clock rising edges after the falling device-clock edge that carries the last stop bit: two synchroniser stages, then the decode register. For each frame it sends, the bench records `evt_valid` one time unit after the third rising edge and again after the fourth. It expects the pair to be high then low on a report's final byte, and low then low on every other byte. Event fields are compared once the whole frame has ended, so they are read well after that edge. Dropped, aborted and partial reports are checked by confirming that the pulse count and the held fields do not change.

// File: rtl/ps2_mouse_decoder.sv
module ps2_mouse_decoder #(
  parameter int IDLE_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk,
  input  logic       ps2_dat,
  output logic       evt_valid,
  output logic [8:0] dx,
  output logic [8:0] dy,
  output logic       btn_left,
  output logic       btn_right,
  output logic       btn_middle,
  output logic       ovf_x,
  output logic       ovf_y
);
  localparam int IW = $clog2(IDLE_CYCLES + 1);

  logic [2:0]    ck_s;
  logic [1:0]    dt_s;
  logic [3:0]    bit_cnt;
  logic [9:0]    shreg;
  logic [IW-1:0] idle;
  logic [1:0]    slot;
  logic [7:0]    hdr, xb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '1;
      dt_s <= '1;
    end else begin
      ck_s <= {ck_s[1:0], ps2_clk};
      dt_s <= {dt_s[0], ps2_dat};
    end
  end

  wire       fall      = ck_s[2] & ~ck_s[1];
  wire       frame_end = fall && (bit_cnt == 4'd10);
  wire [7:0] rx_byte   = shreg[8:1];
  wire       frame_ok  = !shreg[0] && dt_s[1] && (^shreg[9:1]);
  wire       byte_ok   = frame_end && frame_ok;
  wire       byte_err  = frame_end && !frame_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      idle    <= '0;
    end else if (fall) begin
      bit_cnt <= (bit_cnt == 4'd10) ? 4'd0 : bit_cnt + 4'd1;
      shreg   <= {dt_s[1], shreg[9:1]};
      idle    <= '0;
    end else if (bit_cnt != 4'd0) begin
      if (idle == IW'(IDLE_CYCLES)) begin
        bit_cnt <= '0;
        idle    <= '0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= '0;
      hdr        <= '0;
      xb         <= '0;
      evt_valid  <= 1'b0;
      dx         <= '0;
      dy         <= '0;
      btn_left   <= 1'b0;
      btn_right  <= 1'b0;
      btn_middle <= 1'b0;
      ovf_x      <= 1'b0;
      ovf_y      <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (byte_err) begin
        slot <= '0;
      end else if (byte_ok) begin
        case (slot)
          2'd0: if (rx_byte[3]) begin
            hdr  <= rx_byte;
            slot <= 2'd1;
          end
          2'd1: begin
            xb   <= rx_byte;
            slot <= 2'd2;
          end
          default: begin
            dx         <= {hdr[4], xb};
            dy         <= {hdr[5], rx_byte};
            btn_left   <= hdr[0];
            btn_right  <= hdr[1];
            btn_middle <= hdr[2];
            ovf_x      <= hdr[6];
            ovf_y      <= hdr[7];
            evt_valid  <= 1'b1;
            slot       <= 2'd0;
          end
        endcase
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R5
  AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ok |=> $stable(dx) && $stable(dy) && $stable(ovf_x) && $stable(ovf_y)); // R6
  AST_HDR_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != 2'd0) |-> hdr[3]); // R7
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_err |=> (slot == 2'd0) && !evt_valid); // R8
  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && bit_cnt != 4'd0 && idle == IW'(IDLE_CYCLES)) |=> (bit_cnt == 4'd0)); // R9
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd10); // R2
endmodule

// File: tb/ps2_mouse_decoder_test.sv
module ps2_mouse_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b1, pdat = 1'b1;
  logic evt_valid, btn_left, btn_right, btn_middle, ovf_x, ovf_y;
  logic [8:0] dx, dy;
  int nchk = 0, nerr = 0, npulse = 0;
  logic v3, v4;

  always #10 clk = ~clk;

  ps2_mouse_decoder #(.IDLE_CYCLES(3000)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk(pclk), .ps2_dat(pdat),
    .evt_valid(evt_valid), .dx(dx), .dy(dy), .btn_left(btn_left),
    .btn_right(btn_right), .btn_middle(btn_middle), .ovf_x(ovf_x), .ovf_y(ovf_y));

  always @(posedge clk) if (evt_valid) npulse++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pbit(input logic b, input bit last);
    pdat = b;
    repeat (8) @(negedge clk);
    pclk = 1'b0;
    if (last) begin
      repeat (3) @(posedge clk);
      #1 v3 = evt_valid;
      @(posedge clk);
      #1 v4 = evt_valid;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    pclk = 1'b1;
  endtask

  task automatic frame(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
    pbit(1'b0, 0);
    for (int i = 0; i < 8; i++) pbit(b[i], 0);
    pbit((~^b) ^ bad_par, 0);
    pbit(~bad_stop, 1);
    pdat = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic packet(input logic [7:0] h, input logic [7:0] x, input logic [7:0] y);
    frame(h);
    frame(x);
    frame(y);
  endtask

  task automatic expect_evt(input string tag, input logic [7:0] h, input logic [7:0] x, input logic [7:0] y);
    chk({tag, " R4 dx"}, int'(dx), int'({h[4], x}));
    chk({tag, " R4 dy"}, int'(dy), int'({h[5], y}));
    chk({tag, " R3 buttons"}, int'({btn_middle, btn_right, btn_left}), int'(h[2:0]));
    chk({tag, " R3 overflow"}, int'({ovf_y, ovf_x}), int'(h[7:6]));
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(evt_valid), 0);
    chk("R1 dx/dy", int'({dx, dy}), 0);
    chk("R1 flags", int'({btn_left, btn_right, btn_middle, ovf_x, ovf_y}), 0);
  endtask

  task automatic t_basic;
    int p0 = npulse;
    packet(8'h09, 8'h05, 8'h03);
    chk("R5 strobe on third byte", int'({v3, v4}), 2);
    chk("R5 one pulse", npulse - p0, 1);
    expect_evt("R2 basic", 8'h09, 8'h05, 8'h03);
  endtask

  task automatic t_negative;
    int p0 = npulse;
    packet(8'hFE, 8'hF6, 8'h80);
    chk("R4 signed dx", $signed(dx), -10);
    chk("R4 signed dy", $signed(dy), -128);
    expect_evt("R3 neg", 8'hFE, 8'hF6, 8'h80);
    chk("R5 one pulse", npulse - p0, 1);
  endtask

  task automatic t_hold;
    int p0 = npulse;
    frame(8'h0B);
    chk("R5 no strobe mid-report", int'({v3, v4}), 0);
    frame(8'h11);
    chk("R6 partial count", npulse - p0, 0);
    expect_evt("R6 held", 8'hFE, 8'hF6, 8'h80);
    frame(8'h22, 0, 1);
    chk("R8 bad stop no pulse", npulse - p0, 0);
    expect_evt("R8 held", 8'hFE, 8'hF6, 8'h80);
  endtask

  task automatic t_align;
    int p0 = npulse;
    frame(8'h37);
    packet(8'h1A, 8'h40, 8'h02);
    chk("R7 one pulse", npulse - p0, 1);
    expect_evt("R7 realign", 8'h1A, 8'h40, 8'h02);
  endtask

  task automatic t_error;
    int p0 = npulse;
    frame(8'h08);
    frame(8'h33, 1);
    packet(8'h29, 8'h7F, 8'hC0);
    chk("R8 one pulse", npulse - p0, 1);
    expect_evt("R8 restart", 8'h29, 8'h7F, 8'hC0);
  endtask

  task automatic t_timeout;
    int p0 = npulse;
    pbit(1'b0, 0);
    pbit(1'b1, 0);
    pbit(1'b0, 0);
    pdat = 1'b1;
    repeat (3100) @(negedge clk);
    packet(8'h0C, 8'h01, 8'hFF);
    chk("R9 one pulse", npulse - p0, 1);
    expect_evt("R9 flushed", 8'h0C, 8'h01, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_basic();
    t_negative();
    t_hold();
    t_align();
    t_error();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule